// File: doc/BRIEF.md
# Qualified Event-Counting Performance Monitor

This block gives a processor core two hardware event counters, each 40 bits wide. Every cycle each channel picks one event source from a small bank. It adds up the sub-lanes of that source that its lane mask enables. It then passes the per-cycle total through a qualifier stage before the total reaches the counter. The qualifier stage can apply a threshold compare, with an optional invert. It can reduce the condition to its rising edges. It can also filter on the privilege level at which the core is running.

Software programs each channel through a small word-wide register port. Through the same port it reads and writes both counters and polls a sticky overflow status. A counter that wraps raises a level interrupt request if its channel allows it. Some event sources may be placed on only one of the two channels. A control write that tries to put such a source on the other channel lands with the channel switched off.

Top module: `evmon_top`

## Requirements
- R1: The register map is as follows. Address 0 is the control word of channel 0 and address 1 that of channel 1. Addresses 2 and 3 hold counter 0: low 32 bits, then high 8 bits. Addresses 4 and 5 hold counter 1 in the same way. Address 6 is the overflow status, with bit n for channel n. `rd_data_o` shows the addressed register one clock after `rd_addr_i` is presented. Reset clears every register and the read port.
- R2: With a threshold of zero, an enabled channel adds the full per-cycle total (which can exceed 1) in every cycle its privilege filter allows, and the invert bit has no effect.
- R3: With a non-zero threshold and invert clear, the counter steps by exactly 1 in each allowed cycle whose total is greater than or equal to the threshold.
- R4: With a non-zero threshold and invert set, the counter steps by 1 in each allowed cycle whose total is below the threshold.
- R5: With edge mode set, the counter steps by 1 only when the qualified condition turns from false to true. With a zero threshold that condition is total > 0. The remembered previous condition is cleared whenever the channel is disabled.
- R6: The kernel enable permits counting in cycles where `priv_i` is 0. The user enable permits counting where `priv_i` is 1, 2 or 3. With both enables clear, the channel never counts.
- R7: Each event source has two lanes. Lane 0 carries the count from this agent and lane 1 the count from other agents. Bit 0 of the lane mask adds lane 0 and bit 1 adds lane 1.
- R8: Source 3 is legal only on channel 0 and source 2 only on channel 1. A control write that places one of them on the other channel is stored with its enable bit cleared and every other field kept.
- R9: A counter wrap from all ones sets that channel's status bit. The bit stays set until software writes 1 to it at address 6; writing 0 leaves it alone. `irq_o` is high while any status bit is set whose channel has its interrupt enable set.
- R10: A software write to a counter half in the same cycle as an increment wins: the written value is stored and that cycle's increment is lost.
- R11: Source e, lane l drives bits [(e*2+l)*3 +: 3] of `ev_i`, and a channel counts only the source named by its event select.
- R12: The control word is laid out as follows. The event select is bits 1:0, the lane mask bits 3:2 and the threshold bits 7:4. Edge is bit 8, invert bit 9, kernel enable bit 10, user enable bit 11, interrupt enable bit 12 and channel enable bit 13. Higher bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege level of the core |
| ev_i | input | 24 | Per-cycle counts of all sources and lanes |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The main sweep runs every threshold from 0 to 15 against an arithmetic lane pattern, crossed with invert, edge mode, each privilege-filter setting and every non-empty lane mask. Each setting takes all four sources on the channels that may hold them. Other sources carry different values, so a wrong select, lane sum or threshold comparison gives a wrong total. Zero-threshold runs set raw accumulation apart from one-per-cycle stepping, and edge runs set rising-edge counts apart from level counts. Directed cases then cover the following:
- a counter preloaded near the top, which checks wrap, the sticky status and the interrupt enable;
- a counter write that coincides with an increment;
- restricted-source writes to both channels.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned PRIV_W    = 2;
  localparam int unsigned ADDR_W    = 3;

  // Flag offsets above the threshold field of a control word
  localparam int unsigned F_EDGE    = 0;
  localparam int unsigned F_INV     = 1;
  localparam int unsigned F_KERN    = 2;
  localparam int unsigned F_USER    = 3;
  localparam int unsigned F_IE      = 4;
  localparam int unsigned F_EN      = 5;
  localparam int unsigned NUM_FLAGS = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_CTL0    = 3'd0,
    A_CTL1    = 3'd1,
    A_CNT0_LO = 3'd2,
    A_CNT0_HI = 3'd3,
    A_CNT1_LO = 3'd4,
    A_CNT1_HI = 3'd5,
    A_STATUS  = 3'd6
  } reg_addr_e;

endpackage

// File: rtl/evmon_event_sel.sv
module evmon_event_sel #(
  parameter int NUM_EV   = 4,
  parameter int NUM_LANE = 2,
  parameter int LANE_W   = 3,
  parameter int SEL_W    = 2,
  parameter int SUM_W    = 4
) (
  input  logic [NUM_EV*NUM_LANE*LANE_W-1:0] ev_i,
  input  logic [SEL_W-1:0]                  sel_i,
  input  logic [NUM_LANE-1:0]               umask_i,
  output logic [SUM_W-1:0]                  sum_o
);

  // Sum the lanes of the selected source that the lane mask enables
  always_comb begin
    sum_o = '0;
    for (int l = 0; l < NUM_LANE; l++) begin
      if (umask_i[l]) begin
        sum_o = sum_o + SUM_W'(ev_i[(int'(sel_i) * NUM_LANE + l) * LANE_W +: LANE_W]);
      end
    end
  end

endmodule

// File: rtl/evmon_qualify.sv
module evmon_qualify
  import evmon_pkg::*;
#(
  parameter int SUM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              edge_i,
  input  logic              inv_i,
  input  logic              kern_i,
  input  logic              user_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [SUM_W-1:0]  thr_i,
  input  logic [SUM_W-1:0]  cnt_i,
  output logic [SUM_W-1:0]  inc_o,
  output logic              prev_o
);

  logic lvl_ok;
  logic pass;
  logic cond;
  logic prev_q;

  always_comb begin
    lvl_ok = (priv_i == '0) ? kern_i : user_i;
    if (thr_i == '0) begin
      pass = (cnt_i != '0);
    end else if (inv_i) begin
      pass = (cnt_i < thr_i);
    end else begin
      pass = (cnt_i >= thr_i);
    end
    cond = pass & lvl_ok;

    inc_o = '0;
    if (en_i) begin
      if (edge_i) begin
        inc_o = SUM_W'(cond & ~prev_q);
      end else if (thr_i == '0) begin
        inc_o = lvl_ok ? cnt_i : '0;
      end else begin
        inc_o = SUM_W'(cond);
      end
    end
  end

  // Previous condition, forced false while the channel is off
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= cond;
    end
  end

  assign prev_o = prev_q;

endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int CNT_W = 40,
  parameter int BUS_W = 32,
  parameter int SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;

  assign nxt = {1'b0, cnt_q} + (CNT_W + 1)'(inc_i);

  // Software write has priority over the increment
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q[BUS_W-1:0] <= wr_data_i;
    end else if (wr_hi_i) begin
      cnt_q[CNT_W-1:BUS_W] <= wr_data_i[HI_W-1:0];
    end else begin
      cnt_q <= nxt[CNT_W-1:0];
    end
  end

  assign wrap_o = nxt[CNT_W] & ~wr_lo_i & ~wr_hi_i;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int              NUM_EV   = 4,
  parameter int              NUM_LANE = 2,
  parameter int              LANE_W   = 3,
  parameter int              BUS_W    = 32,
  parameter int              CNT_W    = 40,
  parameter logic [NUM_EV-1:0] ONLY_CH0 = 4'b1000,
  parameter logic [NUM_EV-1:0] ONLY_CH1 = 4'b0100
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [PRIV_W-1:0]                priv_i,
  input  logic [NUM_EV*NUM_LANE*LANE_W-1:0] ev_i,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [BUS_W-1:0]                 wr_data_i,
  input  logic [ADDR_W-1:0]                rd_addr_i,
  output logic [BUS_W-1:0]                 rd_data_o,
  output logic                             irq_o
);

  localparam int SEL_W  = $clog2(NUM_EV);
  localparam int SUM_W  = LANE_W + $clog2(NUM_LANE);
  localparam int THR_W  = SUM_W;
  localparam int SEL_LO = 0;
  localparam int UM_LO  = SEL_LO + SEL_W;
  localparam int THR_LO = UM_LO + NUM_LANE;
  localparam int FLG_LO = THR_LO + THR_W;
  localparam int CTL_W  = FLG_LO + NUM_FLAGS;

  logic [NUM_CH-1:0][CTL_W-1:0] ctl_all;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0]            wrap_all;
  logic [NUM_CH-1:0]            prev_all;
  logic [NUM_CH-1:0]            ie_all;
  logic [NUM_CH-1:0]            en_all;
  logic [NUM_CH-1:0]            ovf_q;
  logic [NUM_CH-1:0]            ovf_clr;
  logic [BUS_W-1:0]             rd_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ch);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(2 + 2 * ch);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(3 + 2 * ch);
    localparam logic [NUM_EV-1:0] BARRED = (ch == 0) ? ONLY_CH1 : ONLY_CH0;

    logic             ctl_wr;
    logic             lo_wr;
    logic             hi_wr;
    logic [CTL_W-1:0] new_ctl;
    logic [CTL_W-1:0] ctl_q;
    logic [SUM_W-1:0] ev_sum;
    logic [SUM_W-1:0] inc;

    assign ctl_wr = wr_en_i && (wr_addr_i == A_CTL);
    assign lo_wr  = wr_en_i && (wr_addr_i == A_LO);
    assign hi_wr  = wr_en_i && (wr_addr_i == A_HI);

    // A source barred from this channel lands with the enable cleared
    always_comb begin
      new_ctl = wr_data_i[CTL_W-1:0];
      if (BARRED[new_ctl[SEL_LO +: SEL_W]]) begin
        new_ctl[FLG_LO + F_EN] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q <= '0;
      end else if (ctl_wr) begin
        ctl_q <= new_ctl;
      end
    end

    evmon_event_sel #(
      .NUM_EV  (NUM_EV),
      .NUM_LANE(NUM_LANE),
      .LANE_W  (LANE_W),
      .SEL_W   (SEL_W),
      .SUM_W   (SUM_W)
    ) u_sel (
      .ev_i   (ev_i),
      .sel_i  (ctl_q[SEL_LO +: SEL_W]),
      .umask_i(ctl_q[UM_LO +: NUM_LANE]),
      .sum_o  (ev_sum)
    );

    evmon_qualify #(
      .SUM_W(SUM_W)
    ) u_qual (
      .clk   (clk),
      .rst   (rst),
      .en_i  (ctl_q[FLG_LO + F_EN]),
      .edge_i(ctl_q[FLG_LO + F_EDGE]),
      .inv_i (ctl_q[FLG_LO + F_INV]),
      .kern_i(ctl_q[FLG_LO + F_KERN]),
      .user_i(ctl_q[FLG_LO + F_USER]),
      .priv_i(priv_i),
      .thr_i (ctl_q[THR_LO +: THR_W]),
      .cnt_i (ev_sum),
      .inc_o (inc),
      .prev_o(prev_all[ch])
    );

    evmon_counter #(
      .CNT_W(CNT_W),
      .BUS_W(BUS_W),
      .SUM_W(SUM_W)
    ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .inc_i    (inc),
      .wr_lo_i  (lo_wr),
      .wr_hi_i  (hi_wr),
      .wr_data_i(wr_data_i),
      .cnt_o    (cnt_all[ch]),
      .wrap_o   (wrap_all[ch])
    );

    assign ctl_all[ch] = ctl_q;
    assign ie_all[ch]  = ctl_q[FLG_LO + F_IE];
    assign en_all[ch]  = ctl_q[FLG_LO + F_EN];
  end

  // Sticky overflow status, write-one-to-clear; a new wrap wins over a clear
  assign ovf_clr = (wr_en_i && (wr_addr_i == A_STATUS)) ? wr_data_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | wrap_all;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr_i)
        A_CTL0:    rd_q <= BUS_W'(ctl_all[0]);
        A_CTL1:    rd_q <= BUS_W'(ctl_all[1]);
        A_CNT0_LO: rd_q <= cnt_all[0][BUS_W-1:0];
        A_CNT0_HI: rd_q <= BUS_W'(cnt_all[0][CNT_W-1:BUS_W]);
        A_CNT1_LO: rd_q <= cnt_all[1][BUS_W-1:0];
        A_CNT1_HI: rd_q <= BUS_W'(cnt_all[1][CNT_W-1:BUS_W]);
        A_STATUS:  rd_q <= BUS_W'(ovf_q);
        default:   rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = |(ovf_q & ie_all);

endmodule

// File: rtl/evmon_chk.sv
module evmon_chk
  import evmon_pkg::*;
#(
  parameter int              NUM_EV   = 4,
  parameter int              CNT_W    = 40,
  parameter int              BUS_W    = 32,
  parameter int              SEL_W    = 2,
  parameter int              THR_W    = 4,
  parameter logic [NUM_EV-1:0] ONLY_CH0 = 4'b1000,
  parameter logic [NUM_EV-1:0] ONLY_CH1 = 4'b0100
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BUS_W-1:0]  wr_data,
  input logic [1:0]        en,
  input logic [SEL_W-1:0]  sel0,
  input logic [SEL_W-1:0]  sel1,
  input logic [THR_W-1:0]  thr0,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1,
  input logic [1:0]        ovf,
  input logic [1:0]        prev,
  input logic              irq
);

  logic wr_c0;
  logic wr_c1;
  assign wr_c0 = wr_en && (wr_addr == A_CNT0_LO || wr_addr == A_CNT0_HI);
  assign wr_c1 = wr_en && (wr_addr == A_CNT1_LO || wr_addr == A_CNT1_HI);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CNT0_LO) |=> (cnt0[BUS_W-1:0] == $past(wr_data)));

  a_r2_hold_ch0: assert property (@(posedge clk) disable iff (rst)
    (!en[0] && !wr_c0) |=> $stable(cnt0));

  a_r2_hold_ch1: assert property (@(posedge clk) disable iff (rst)
    (!en[1] && !wr_c1) |=> $stable(cnt1));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    (en[0] && thr0 != '0 && !wr_c0) |=> ((cnt0 - $past(cnt0)) <= CNT_W'(1)));

  a_r5_prev_clear0: assert property (@(posedge clk) disable iff (rst)
    !en[0] |=> !prev[0]);

  a_r5_prev_clear1: assert property (@(posedge clk) disable iff (rst)
    !en[1] |=> !prev[1]);

  a_r8_ch0_place: assert property (@(posedge clk) disable iff (rst)
    !(en[0] && ONLY_CH1[sel0]));

  a_r8_ch1_place: assert property (@(posedge clk) disable iff (rst)
    !(en[1] && ONLY_CH0[sel1]));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && !(wr_en && wr_addr == A_STATUS && wr_data[0])) |=> ovf[0]);

  a_r9_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ovf != 2'b00));

endmodule

bind evmon_top evmon_chk #(
  .NUM_EV  (NUM_EV),
  .CNT_W   (CNT_W),
  .BUS_W   (BUS_W),
  .SEL_W   (SEL_W),
  .THR_W   (THR_W),
  .ONLY_CH0(ONLY_CH0),
  .ONLY_CH1(ONLY_CH1)
) u_evmon_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en_i),
  .wr_addr(wr_addr_i),
  .wr_data(wr_data_i),
  .en     (en_all),
  .sel0   (ctl_all[0][SEL_LO +: SEL_W]),
  .sel1   (ctl_all[1][SEL_LO +: SEL_W]),
  .thr0   (ctl_all[0][THR_LO +: THR_W]),
  .cnt0   (cnt_all[0]),
  .cnt1   (cnt_all[1]),
  .ovf    (ovf_q),
  .prev   (prev_all),
  .irq    (irq_o)
);

// File: tb/test_evmon_top.sv
`timescale 1ns/1ps
module test_evmon_top;

  localparam int NUM_EV = 4, NUM_LANE = 2, LANE_W = 3, N = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  priv = '0;
  logic [NUM_EV*NUM_LANE*LANE_W-1:0] ev = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  wire  [31:0] rd_data;
  wire         irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evmon_top i_evmon_top (
    .clk(clk), .rst(rst), .priv_i(priv), .ev_i(ev),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic int lane_val(int e, int l, int i);
    return (i * (3 + 2 * l) + e * (l + 2) + l) % 8;
  endfunction

  function automatic int priv_at(int i);
    return (i + i / 3) % 4;
  endfunction

  // Control word layout per R12
  function automatic logic [31:0] mk_ctl(int sel, int um, int thr, bit ed, bit inv,
                                         bit kn, bit us, bit ie, bit en);
    return {18'b0, en, ie, us, kn, inv, ed, 4'(thr), 2'(um), 2'(sel)};
  endfunction

  // Expected count from R2..R7, R11
  function automatic logic [63:0] model(int sel, int um, int thr, bit ed, bit inv,
                                        bit kn, bit us);
    logic [63:0] acc = '0;
    bit prv = 1'b0;
    for (int i = 0; i < N; i++) begin
      int  c = ((um & 1) != 0 ? lane_val(sel, 0, i) : 0) + ((um & 2) != 0 ? lane_val(sel, 1, i) : 0);
      bit  ok = (priv_at(i) == 0) ? kn : us;
      bit  pass = (thr == 0) ? (c != 0) : (inv ? (c < thr) : (c >= thr));
      bit  cond = pass && ok;
      if (ed) begin
        if (cond && !prv) acc = acc + 1;
        prv = cond;
      end else if (thr == 0) begin
        acc = acc + (ok ? 64'(c) : 64'd0);
      end else begin
        acc = acc + (cond ? 64'd1 : 64'd0);
      end
    end
    return acc;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic drive_cycle(int i);
    for (int e = 0; e < NUM_EV; e++)
      for (int l = 0; l < NUM_LANE; l++)
        ev[(e * NUM_LANE + l) * LANE_W +: LANE_W] = 3'(lane_val(e, l, i));
    priv = 2'(priv_at(i));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic rd_cnt(int ch, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'(2 + 2 * ch), lo);
    rd(3'(3 + 2 * ch), hi);
    v = {24'b0, hi[7:0], lo};
  endtask

  task automatic run_case(int ch, int sel, int um, int thr, bit ed, bit inv, bit kn, bit us);
    logic [63:0] got;
    string tag;
    wr(3'(2 + 2 * ch), 32'd0);
    wr(3'(3 + 2 * ch), 32'd0);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(ch); wr_data = mk_ctl(sel, um, thr, ed, inv, kn, us, 1'b0, 1'b1);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      drive_cycle(i);
      if (i == N - 1) begin
        wr_en = 1'b1; wr_data = mk_ctl(sel, um, thr, ed, inv, kn, us, 1'b0, 1'b0);
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk); wr_en = 1'b0;
    rd_cnt(ch, got);
    tag = ed ? "R5" : (thr == 0 ? "R2" : (inv ? "R4" : "R3"));
    chk($sformatf("%s (R6 R7 R11) ch=%0d sel=%0d um=%0d thr=%0d inv=%0d k=%0d u=%0d",
                  tag, ch, sel, um, thr, inv, kn, us),
        got, model(sel, um, thr, ed, inv, kn, us));
  endtask

  task automatic ovf_case(bit ie);
    logic [31:0] d;
    logic [63:0] v;
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd3, 32'h0000_00FF);
    ev = '0; ev[2:0] = 3'd3; priv = 2'd0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = mk_ctl(0, 1, 0, 0, 0, 1, 1, ie, 1);
    @(negedge clk); wr_data = mk_ctl(0, 1, 0, 0, 0, 1, 1, ie, 0);
    @(negedge clk); wr_en = 1'b0;
    chk($sformatf("R9 irq after wrap ie=%0d", ie), 64'(irq), 64'(ie));
    rd(3'd6, d);
    chk("R9 status set on wrap", 64'(d), 64'd1);
    rd_cnt(0, v);
    chk("R9 counter wrapped value", v, 64'd1);
    wr(3'd6, 32'd0);
    rd(3'd6, d);
    chk("R9 writing 0 keeps status", 64'(d), 64'd1);
    wr(3'd6, 32'd1);
    rd(3'd6, d);
    chk("R9 writing 1 clears status", 64'(d), 64'd0);
    chk("R9 irq low after clear", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register and the interrupt
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reset value addr=%0d", a), 64'(d), 64'd0);
    end
    chk("R1 irq after reset", 64'(irq), 64'd0);

    // R1: counter halves, high half is 8 bits wide
    wr(3'd5, 32'hFFFF_FFA5);
    wr(3'd4, 32'h1234_5678);
    rd(3'd5, d);
    chk("R1 counter 1 high half", 64'(d), 64'hA5);
    rd(3'd4, d);
    chk("R1 counter 1 low half", 64'(d), 64'h1234_5678);

    // R8: restricted sources
    wr(3'd1, mk_ctl(3, 1, 0, 0, 0, 1, 1, 0, 1));
    rd(3'd1, d);
    chk("R8 source 3 on channel 1 stored disabled", 64'(d), 64'(mk_ctl(3, 1, 0, 0, 0, 1, 1, 0, 0)));
    wr(3'd0, mk_ctl(2, 3, 5, 1, 0, 1, 0, 1, 1));
    rd(3'd0, d);
    chk("R8 source 2 on channel 0 stored disabled", 64'(d), 64'(mk_ctl(2, 3, 5, 1, 0, 1, 0, 1, 0)));
    wr(3'd0, mk_ctl(3, 2, 1, 0, 1, 0, 1, 0, 1));
    rd(3'd0, d);
    chk("R8 source 3 on channel 0 kept enabled", 64'(d), 64'(mk_ctl(3, 2, 1, 0, 1, 0, 1, 0, 1)));
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);

    // R10: counter write wins over a same-cycle increment
    wr(3'd2, 32'd0); wr(3'd3, 32'd0);
    ev = '0; ev[2:0] = 3'd2; priv = 2'd0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = mk_ctl(0, 1, 0, 0, 0, 1, 1, 0, 1);
    @(negedge clk); wr_addr = 3'd2; wr_data = 32'd100;
    @(negedge clk); wr_addr = 3'd0; wr_data = mk_ctl(0, 1, 0, 0, 0, 1, 1, 0, 0);
    @(negedge clk); wr_en = 1'b0;
    rd_cnt(0, v);
    chk("R10 write beats increment", v, 64'd102);

    // R9: wrap, sticky status, interrupt enable
    ovf_case(1'b1);
    ovf_case(1'b0);

    // R2..R7, R11 sweep
    for (int sel = 0; sel < 4; sel++) begin
      for (int thr = 0; thr < 16; thr++)
        for (int md = 0; md < 4; md++)
          for (int pm = 1; pm < 4; pm++)
            for (int um = 1; um < 4; um++)
              run_case((sel == 0 || sel == 3) ? 0 : 1, sel, um, thr,
                       md[1], md[0], pm[0], pm[1]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule